// File: doc/BRIEF.md
# Option Byte Protection Unit

This unit keeps a small non-volatile option area of eight byte-wide entries. Each entry is held as a half-word: the value sits in the low byte and its bitwise complement in the high byte. The unit always computes that complement itself. From the stored entries it derives per-page write-protect flags for the main array, a read-protect state, three configuration outputs and two free user bytes. The flash array, the key unlock sequence and the watchdog and low-power logic that consume the configuration bits all sit outside this unit.

Software changes the area through two commands. Both are accepted only while the external unlock input is high and no other operation is in progress. An area erase returns every entry to the blank half-word 0xFFFF. A program write fills one blank entry. Lowering read protection is an exception: before the new value is committed, the unit requests a mass erase of the main array and waits for the array controller to acknowledge it. While read protection is active and the debug input is high, array read requests are refused.

Top module: `optbyte_guard`

## Requirements
- R1: After reset all eight entries are blank (0xFFFF). Read protection is active, every page flag is set, all configuration outputs are 0, both user bytes read 0xFF, and busy and the mass-erase request are low.
- R2: A program write stores only the low byte of `wr_data_i` and pairs it with its computed complement. The high byte of `wr_data_i` has no effect on any output.
- R3: Entries 4 to 7 are write-protect masks. Bit b of entry 4+k, when set, protects group 8k+b, and group g covers pages g*P to g*P+P-1, where P = NUM_PAGES/32. A blank mask entry protects nothing.
- R4: A program write aimed at an entry that is not blank is ignored: busy stays low and the outputs do not change.
- R5: An area erase is requested when the erase select and start inputs are high in the same cycle. It keeps busy high for ERASE_CYC cycles and then leaves all entries blank. This removes every mask protection and turns read protection back on.
- R6: Entry 0 is the read-protect entry. Read protection is inactive only while entry 0 holds the value 0xFA with its complement. Programming 0xFA while protection is active raises `merase_req_o` and holds it until `merase_done_i`. Read protection stays active until the entry is committed afterwards.
- R7: While read protection is active and `dbg_mode_i` is high, `rd_grant_o` is 0. Otherwise `rd_grant_o` follows `rd_req_i`.
- R8: While read protection is active, every bit of `page_wp_o` is 1.
- R9: Entry 1 is the configuration entry. A clear bit 0 selects hardware watchdog start, a clear bit 1 requests a reset on stop entry, and a clear bit 2 requests a reset on standby entry. Each output is active high and is 0 while the entry is blank.
- R10: Program and erase commands are ignored while `unlock_i` is low or while busy is high.
- R11: A program write that needs no mass erase keeps busy high for exactly PROG_CYC cycles.
- R12: When erase and program are requested in the same cycle, only the erase is performed.
- R13: Entries 2 and 3 appear unchanged on `usr0_o` and `usr1_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low reset; loads the blank area |
| unlock_i | input | 1 | High when the external key logic has unlocked changes |
| erase_sel_i | input | 1 | Selects area erase |
| start_i | input | 1 | Starts the selected erase |
| prog_sel_i | input | 1 | Enables program writes |
| wr_valid_i | input | 1 | Program write strobe |
| wr_idx_i | input | 3 | Entry index for the program write |
| wr_data_i | input | 16 | Half-word written; only bits 7:0 are used |
| busy_o | output | 1 | An operation is in progress |
| merase_req_o | output | 1 | Mass-erase request to the array controller |
| merase_done_i | input | 1 | Mass erase finished |
| dbg_mode_i | input | 1 | Debug access is active |
| rd_req_i | input | 1 | Array read request |
| rd_grant_o | output | 1 | Array read allowed |
| rdp_active_o | output | 1 | Read protection in force |
| page_wp_o | output | NUM_PAGES | Per-page write-protect flags |
| cfg_hw_wdg_o | output | 1 | Watchdog starts in hardware |
| cfg_rst_stop_o | output | 1 | Reset on stop entry |
| cfg_rst_stby_o | output | 1 | Reset on standby entry |
| usr0_o | output | 8 | User byte in entry 2 |
| usr1_o | output | 8 | User byte in entry 3 |

## Verification
Mask decoding is exercised with a sparse pattern in the first mask entry, written with a junk high byte, and a single top bit in the last entry. The junk high byte shows whether the supplied upper half is used or the complement is computed. The two entries together place the group bits at both ends of the page vector. Commands are also sent into a blank entry, into an already written entry, while locked, while busy and together with an erase. Each of these shows whether an acceptance condition is missing or whether the priority order is wrong. The read-protect entry is lowered twice, once from the reset state and once after an erase. Both times the bench watches that protection holds while the mass-erase request is open, and that reads are refused under debug only while protection is active.

// File: rtl/optg_pkg.sv
package optg_pkg;

   localparam int BYTE_W      = 8;
   localparam int NUM_ENTRIES = 8;
   localparam int IDX_W       = $clog2(NUM_ENTRIES);

   // entry placement: the decode depends on these positions
   localparam int IDX_RDP  = 0;
   localparam int IDX_CFG  = 1;
   localparam int IDX_USR0 = 2;
   localparam int IDX_USR1 = 3;
   localparam int IDX_WP0  = 4;
   localparam int NUM_WP   = 4;
   localparam int NUM_GROUPS = NUM_WP * BYTE_W;

   typedef logic [2*BYTE_W-1:0] hword_t;
   localparam hword_t BLANK_HW = '1;

   typedef enum logic [1:0] {ES_BLANK, ES_GOOD, ES_BAD} entry_st_e;
   typedef enum logic [1:0] {ST_IDLE, ST_MERASE, ST_PROG, ST_ERASE} seq_st_e;

   function automatic hword_t pack_pair(input logic [BYTE_W-1:0] v);
      return {~v, v};
   endfunction

   function automatic entry_st_e classify(input hword_t h);
      if (h == BLANK_HW) return ES_BLANK;
      if (h[2*BYTE_W-1:BYTE_W] == ~h[BYTE_W-1:0]) return ES_GOOD;
      return ES_BAD;
   endfunction

endpackage

// File: rtl/optg_store.sv
module optg_store
   import optg_pkg::*;
(
   input  logic                           clk_i,
   input  logic                           rst_ni,
   input  logic                           clr_all_i,
   input  logic                           wr_en_i,
   input  logic [IDX_W-1:0]               wr_idx_i,
   input  logic [BYTE_W-1:0]              wr_val_i,
   output hword_t [NUM_ENTRIES-1:0]       ent_o,
   output logic   [NUM_ENTRIES-1:0]       blank_o
);

   hword_t [NUM_ENTRIES-1:0] ent_q;

   for (genvar e = 0; e < NUM_ENTRIES; e++) begin : g_ent
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            ent_q[e] <= BLANK_HW;
         end else if (clr_all_i) begin
            ent_q[e] <= BLANK_HW;
         end else if (wr_en_i && (wr_idx_i == IDX_W'(e))) begin
            ent_q[e] <= pack_pair(wr_val_i);
         end
      end
      assign blank_o[e] = (classify(ent_q[e]) == ES_BLANK);
   end

   assign ent_o = ent_q;

   // R5: an erase commit leaves every entry blank
   a_r5_erase_blanks: assert property (@(posedge clk_i) disable iff (!rst_ni)
      clr_all_i |=> (&blank_o));

   // R2: the stored high byte is the complement of the value written
   a_r2_pair_stored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (wr_en_i && !clr_all_i) |=>
         (ent_q[$past(wr_idx_i)][2*BYTE_W-1:BYTE_W] == ~$past(wr_val_i)));

endmodule

// File: rtl/optg_decode.sv
module optg_decode
   import optg_pkg::*;
#(
   parameter int               NUM_PAGES    = 64,
   parameter logic [BYTE_W-1:0] RDP_OFF_CODE = 8'hFA
) (
   input  hword_t [NUM_ENTRIES-1:0] ent_i,
   output logic                     rdp_active_o,
   output logic [NUM_PAGES-1:0]     page_wp_o,
   output logic                     cfg_hw_wdg_o,
   output logic                     cfg_rst_stop_o,
   output logic                     cfg_rst_stby_o,
   output logic [BYTE_W-1:0]        usr0_o,
   output logic [BYTE_W-1:0]        usr1_o
);

   localparam int PG_PER_GRP = NUM_PAGES / NUM_GROUPS;

   if ((NUM_PAGES % NUM_GROUPS) != 0 || NUM_PAGES < NUM_GROUPS) begin : g_bad_pages
      $error("NUM_PAGES must be a nonzero multiple of the group count");
   end

   // read protection: only a good entry holding the release code lifts it
   entry_st_e rdp_st;
   assign rdp_st       = classify(ent_i[IDX_RDP]);
   assign rdp_active_o = !((rdp_st == ES_GOOD) &&
                           (ent_i[IDX_RDP][BYTE_W-1:0] == RDP_OFF_CODE));

   // group masks, one byte per mask entry
   logic [NUM_GROUPS-1:0] grp_wp;
   for (genvar w = 0; w < NUM_WP; w++) begin : g_mask
      entry_st_e st;
      assign st = classify(ent_i[IDX_WP0 + w]);
      always_comb begin
         unique case (st)
            ES_BLANK: grp_wp[w*BYTE_W +: BYTE_W] = '0;
            ES_GOOD:  grp_wp[w*BYTE_W +: BYTE_W] = ent_i[IDX_WP0 + w][BYTE_W-1:0];
            default:  grp_wp[w*BYTE_W +: BYTE_W] = '1;
         endcase
      end
   end

   // page fan-out of the groups
   if (PG_PER_GRP == 1) begin : g_direct
      for (genvar p = 0; p < NUM_PAGES; p++) begin : g_pg
         assign page_wp_o[p] = rdp_active_o | grp_wp[p];
      end
   end else begin : g_spread
      for (genvar p = 0; p < NUM_PAGES; p++) begin : g_pg
         assign page_wp_o[p] = rdp_active_o | grp_wp[p / PG_PER_GRP];
      end
   end

   // configuration entry, active-low fields
   entry_st_e cfg_st;
   logic [BYTE_W-1:0] cfg_v;
   assign cfg_st = classify(ent_i[IDX_CFG]);
   assign cfg_v  = ent_i[IDX_CFG][BYTE_W-1:0];

   always_comb begin
      unique case (cfg_st)
         ES_BLANK: {cfg_rst_stby_o, cfg_rst_stop_o, cfg_hw_wdg_o} = 3'b000;
         ES_GOOD:  {cfg_rst_stby_o, cfg_rst_stop_o, cfg_hw_wdg_o} = ~cfg_v[2:0];
         default:  {cfg_rst_stby_o, cfg_rst_stop_o, cfg_hw_wdg_o} = 3'b111;
      endcase
   end

   logic unused_cfg;
   assign unused_cfg = ^cfg_v[BYTE_W-1:3];

   // user bytes
   assign usr0_o = (classify(ent_i[IDX_USR0]) == ES_BAD) ? '1 : ent_i[IDX_USR0][BYTE_W-1:0];
   assign usr1_o = (classify(ent_i[IDX_USR1]) == ES_BAD) ? '1 : ent_i[IDX_USR1][BYTE_W-1:0];

endmodule

// File: rtl/optg_seq.sv
module optg_seq
   import optg_pkg::*;
#(
   parameter int                PROG_CYC     = 4,
   parameter int                ERASE_CYC    = 8,
   parameter logic [BYTE_W-1:0] RDP_OFF_CODE = 8'hFA
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              unlock_i,
   input  logic              erase_cmd_i,
   input  logic              prog_cmd_i,
   input  logic [IDX_W-1:0]  prog_idx_i,
   input  logic [BYTE_W-1:0] prog_val_i,
   input  logic              target_blank_i,
   input  logic              rdp_active_i,
   input  logic              merase_done_i,
   output logic              busy_o,
   output logic              merase_req_o,
   output logic              clr_all_o,
   output logic              wr_en_o,
   output logic [IDX_W-1:0]  wr_idx_o,
   output logic [BYTE_W-1:0] wr_val_o,
   output logic              merase_seen_o
);

   localparam int MAX_CYC = (PROG_CYC > ERASE_CYC) ? PROG_CYC : ERASE_CYC;
   localparam int CNT_W   = $clog2(MAX_CYC + 1);

   if (PROG_CYC < 1 || ERASE_CYC < 1) begin : g_bad_cyc
      $error("operation lengths must be at least one cycle");
   end

   seq_st_e           st_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [IDX_W-1:0]  idx_q;
   logic [BYTE_W-1:0] val_q;
   logic              seen_q;

   logic idle, take_erase, take_prog, drop_rdp, last_prog, last_erase;

   assign idle       = (st_q == ST_IDLE);
   assign take_erase = idle && unlock_i && erase_cmd_i;
   assign take_prog  = idle && unlock_i && prog_cmd_i && !erase_cmd_i && target_blank_i;
   assign drop_rdp   = (prog_idx_i == IDX_W'(IDX_RDP)) && (prog_val_i == RDP_OFF_CODE)
                       && rdp_active_i;
   assign last_prog  = (st_q == ST_PROG)  && (cnt_q == CNT_W'(PROG_CYC - 1));
   assign last_erase = (st_q == ST_ERASE) && (cnt_q == CNT_W'(ERASE_CYC - 1));

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q   <= ST_IDLE;
         cnt_q  <= '0;
         idx_q  <= '0;
         val_q  <= '0;
         seen_q <= 1'b0;
      end else begin
         unique case (st_q)
            ST_IDLE: begin
               cnt_q <= '0;
               if (take_erase) begin
                  st_q <= ST_ERASE;
               end else if (take_prog) begin
                  idx_q <= prog_idx_i;
                  val_q <= prog_val_i;
                  st_q  <= drop_rdp ? ST_MERASE : ST_PROG;
               end
            end
            ST_MERASE: begin
               if (merase_done_i) begin
                  st_q   <= ST_PROG;
                  seen_q <= 1'b1;
                  cnt_q  <= '0;
               end
            end
            ST_PROG: begin
               if (last_prog) begin
                  st_q   <= ST_IDLE;
                  seen_q <= 1'b0;
               end else begin
                  cnt_q <= cnt_q + 1'b1;
               end
            end
            ST_ERASE: begin
               if (last_erase) st_q <= ST_IDLE;
               else            cnt_q <= cnt_q + 1'b1;
            end
            default: st_q <= ST_IDLE;
         endcase
      end
   end

   assign busy_o        = !idle;
   assign merase_req_o  = (st_q == ST_MERASE);
   assign clr_all_o     = last_erase;
   assign wr_en_o       = last_prog;
   assign wr_idx_o      = idx_q;
   assign wr_val_o      = val_q;
   assign merase_seen_o = seen_q;

   // R10: nothing starts while locked
   a_r10_locked_stays_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idle && !unlock_i) |=> (st_q == ST_IDLE));

   // R4: a lone program into a written entry never starts an operation
   a_r4_nonblank_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (idle && prog_cmd_i && !erase_cmd_i && !target_blank_i) |=> (st_q == ST_IDLE));

endmodule

// File: rtl/optbyte_guard.sv
module optbyte_guard
   import optg_pkg::*;
#(
   parameter int                NUM_PAGES    = 64,
   parameter int                PROG_CYC     = 4,
   parameter int                ERASE_CYC    = 8,
   parameter logic [BYTE_W-1:0] RDP_OFF_CODE = 8'hFA
) (
   input  logic                 clk_i,
   input  logic                 rst_ni,
   input  logic                 unlock_i,
   input  logic                 erase_sel_i,
   input  logic                 start_i,
   input  logic                 prog_sel_i,
   input  logic                 wr_valid_i,
   input  logic [2:0]           wr_idx_i,
   input  logic [15:0]          wr_data_i,
   output logic                 busy_o,
   output logic                 merase_req_o,
   input  logic                 merase_done_i,
   input  logic                 dbg_mode_i,
   input  logic                 rd_req_i,
   output logic                 rd_grant_o,
   output logic                 rdp_active_o,
   output logic [NUM_PAGES-1:0] page_wp_o,
   output logic                 cfg_hw_wdg_o,
   output logic                 cfg_rst_stop_o,
   output logic                 cfg_rst_stby_o,
   output logic [7:0]           usr0_o,
   output logic [7:0]           usr1_o
);

   if (IDX_W != 3 || BYTE_W != 8) begin : g_bad_geom
      $error("port widths assume eight byte-wide entries");
   end

   hword_t [NUM_ENTRIES-1:0] ent;
   logic   [NUM_ENTRIES-1:0] blank;
   logic                     clr_all, wr_en, merase_seen;
   logic   [IDX_W-1:0]       st_idx;
   logic   [BYTE_W-1:0]      st_val;

   logic unused_hi;
   assign unused_hi = ^wr_data_i[15:8];

   optg_seq #(
      .PROG_CYC     (PROG_CYC),
      .ERASE_CYC    (ERASE_CYC),
      .RDP_OFF_CODE (RDP_OFF_CODE)
   ) seq_i (
      .clk_i          (clk_i),
      .rst_ni         (rst_ni),
      .unlock_i       (unlock_i),
      .erase_cmd_i    (erase_sel_i && start_i),
      .prog_cmd_i     (prog_sel_i && wr_valid_i),
      .prog_idx_i     (wr_idx_i),
      .prog_val_i     (wr_data_i[7:0]),
      .target_blank_i (blank[wr_idx_i]),
      .rdp_active_i   (rdp_active_o),
      .merase_done_i  (merase_done_i),
      .busy_o         (busy_o),
      .merase_req_o   (merase_req_o),
      .clr_all_o      (clr_all),
      .wr_en_o        (wr_en),
      .wr_idx_o       (st_idx),
      .wr_val_o       (st_val),
      .merase_seen_o  (merase_seen)
   );

   optg_store store_i (
      .clk_i     (clk_i),
      .rst_ni    (rst_ni),
      .clr_all_i (clr_all),
      .wr_en_i   (wr_en),
      .wr_idx_i  (st_idx),
      .wr_val_i  (st_val),
      .ent_o     (ent),
      .blank_o   (blank)
   );

   optg_decode #(
      .NUM_PAGES    (NUM_PAGES),
      .RDP_OFF_CODE (RDP_OFF_CODE)
   ) dec_i (
      .ent_i          (ent),
      .rdp_active_o   (rdp_active_o),
      .page_wp_o      (page_wp_o),
      .cfg_hw_wdg_o   (cfg_hw_wdg_o),
      .cfg_rst_stop_o (cfg_rst_stop_o),
      .cfg_rst_stby_o (cfg_rst_stby_o),
      .usr0_o         (usr0_o),
      .usr1_o         (usr1_o)
   );

   assign rd_grant_o = rd_req_i && !(rdp_active_o && dbg_mode_i);

   // R6: protection only drops after an acknowledged mass erase
   a_r6_erase_before_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $fell(rdp_active_o) |-> $past(merase_seen));

   // R6: the mass-erase request is only open while protection still holds
   a_r6_req_while_active: assert property (@(posedge clk_i) disable iff (!rst_ni)
      merase_req_o |-> rdp_active_o);

   // R8: active read protection locks every page
   a_r8_rdp_locks_all: assert property (@(posedge clk_i) disable iff (!rst_ni)
      rdp_active_o |-> (&page_wp_o));

   // R7: debug reads are refused under protection
   a_r7_dbg_blocks_read: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (rdp_active_o && dbg_mode_i) |-> !rd_grant_o);

endmodule

// File: tb/optbyte_guard_tb_top.sv
`timescale 1ns/1ps
module optbyte_guard_tb_top;

   localparam int NP = 64;
   localparam int PC = 4;
   localparam int EC = 8;

   logic clk = 1'b0;
   logic rst_n;
   logic unlock, erase_sel, start, prog_sel, wr_valid, merase_done, dbg, rd_req;
   logic [2:0]  wr_idx;
   logic [15:0] wr_data;
   logic busy, merase_req, rd_grant, rdp_act, hw_wdg, rst_stop, rst_stby;
   logic [NP-1:0] page_wp;
   logic [7:0] usr0, usr1;

   int n_chk = 0;
   int n_bad = 0;
   int mreq_pulses = 0;
   int mcnt = 0;
   logic mreq_prev = 1'b0;
   logic rdp_low_in_req = 1'b0;

   always #5 clk = ~clk;

   optbyte_guard #(.NUM_PAGES(NP), .PROG_CYC(PC), .ERASE_CYC(EC)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .unlock_i(unlock), .erase_sel_i(erase_sel),
      .start_i(start), .prog_sel_i(prog_sel), .wr_valid_i(wr_valid),
      .wr_idx_i(wr_idx), .wr_data_i(wr_data), .busy_o(busy),
      .merase_req_o(merase_req), .merase_done_i(merase_done), .dbg_mode_i(dbg),
      .rd_req_i(rd_req), .rd_grant_o(rd_grant), .rdp_active_o(rdp_act),
      .page_wp_o(page_wp), .cfg_hw_wdg_o(hw_wdg), .cfg_rst_stop_o(rst_stop),
      .cfg_rst_stby_o(rst_stby), .usr0_o(usr0), .usr1_o(usr1)
   );

   // array controller model: acknowledges a mass erase a few cycles later
   always @(negedge clk) begin
      if (merase_req && !mreq_prev) mreq_pulses <= mreq_pulses + 1;
      if (merase_req && !rdp_act) rdp_low_in_req <= 1'b1;
      mreq_prev <= merase_req;
      if (merase_req && !merase_done) begin
         mcnt <= mcnt + 1;
         if (mcnt == 3) merase_done <= 1'b1;
      end else begin
         merase_done <= 1'b0;
         mcnt <= 0;
      end
   end

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic do_prog(input logic [2:0] idx, input logic [15:0] d, output int cyc);
      @(negedge clk);
      prog_sel = 1'b1; wr_valid = 1'b1; wr_idx = idx; wr_data = d;
      @(negedge clk);
      prog_sel = 1'b0; wr_valid = 1'b0;
      cyc = 0;
      while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
   endtask

   task automatic do_erase(output int cyc);
      @(negedge clk);
      erase_sel = 1'b1; start = 1'b1;
      @(negedge clk);
      erase_sel = 1'b0; start = 1'b0;
      cyc = 0;
      while (busy && cyc < 1000) begin cyc++; @(negedge clk); end
   endtask

   task automatic t_reset();
      chk("R1 read protection after reset", rdp_act, 1);
      chk("R1 page flags after reset", page_wp, {NP{1'b1}});
      chk("R1 config after reset", {rst_stby, rst_stop, hw_wdg}, 0);
      chk("R1 user bytes after reset", {usr1, usr0}, 16'hFFFF);
      chk("R1 busy and request after reset", {busy, merase_req}, 0);
      rd_req = 1'b1; dbg = 1'b1; #1;
      chk("R7 debug read refused when protected", rd_grant, 0);
      dbg = 1'b0; #1;
      chk("R7 normal read granted when protected", rd_grant, 1);
   endtask

   task automatic t_rdp_off();
      int c;
      do_prog(3'd0, 16'h00FA, c);
      chk("R6 one mass-erase request", mreq_pulses, 1);
      chk("R6 protection held during request", rdp_low_in_req, 0);
      chk("R6 protection released", rdp_act, 0);
      chk("R8 pages free once released", page_wp, 0);
      dbg = 1'b1; #1;
      chk("R7 debug read granted when released", rd_grant, 1);
      dbg = 1'b0;
   endtask

   task automatic t_masks();
      int c;
      do_prog(3'd4, 16'hAB05, c);   // junk high byte, R2
      chk("R11 program busy length", c, PC);
      chk("R2 R3 low mask entry", page_wp, 64'h0000_0000_0000_0033);
      do_prog(3'd7, 16'h0080, c);
      chk("R3 top mask entry", page_wp, 64'hC000_0000_0000_0033);
      do_prog(3'd4, 16'h00FF, c);
      chk("R4 rewrite not started", c, 0);
      chk("R4 rewrite left mask", page_wp, 64'hC000_0000_0000_0033);
   endtask

   task automatic t_cfg_user();
      int c;
      do_prog(3'd1, 16'h0006, c);
      chk("R9 config hw watchdog only", {rst_stby, rst_stop, hw_wdg}, 3'b001);
      do_prog(3'd2, 16'h115A, c);
      do_prog(3'd3, 16'h00C3, c);
      chk("R13 user bytes", {usr1, usr0}, 16'hC35A);
   endtask

   task automatic t_locked();
      int c;
      unlock = 1'b0;
      do_prog(3'd5, 16'h0001, c);
      chk("R10 locked program not started", c, 0);
      chk("R10 locked program no effect", page_wp, 64'hC000_0000_0000_0033);
      do_erase(c);
      chk("R10 locked erase not started", c, 0);
      chk("R10 locked erase no effect", rdp_act, 0);
      unlock = 1'b1;
   endtask

   task automatic t_busy_block();
      int c;
      @(negedge clk);
      prog_sel = 1'b1; wr_valid = 1'b1; wr_idx = 3'd5; wr_data = 16'h0001;
      @(negedge clk);
      prog_sel = 1'b0; wr_valid = 1'b0; erase_sel = 1'b1; start = 1'b1;
      @(negedge clk);
      erase_sel = 1'b0; start = 1'b0;
      c = 0;
      while (busy && c < 1000) begin c++; @(negedge clk); end
      chk("R10 erase while busy ignored", rdp_act, 0);
      chk("R10 first program completed", page_wp, 64'hC000_0000_0003_0033);
   endtask

   task automatic t_erase_wins();
      int c;
      @(negedge clk);
      erase_sel = 1'b1; start = 1'b1;
      prog_sel = 1'b1; wr_valid = 1'b1; wr_idx = 3'd6; wr_data = 16'h0001;
      @(negedge clk);
      erase_sel = 1'b0; start = 1'b0; prog_sel = 1'b0; wr_valid = 1'b0;
      c = 0;
      while (busy && c < 1000) begin c++; @(negedge clk); end
      chk("R5 R12 erase busy length", c, EC);
      chk("R5 protection back after erase", rdp_act, 1);
      chk("R5 config cleared", {rst_stby, rst_stop, hw_wdg}, 0);
      chk("R5 user bytes cleared", {usr1, usr0}, 16'hFFFF);
      rd_req = 1'b1; dbg = 1'b1; #1;
      chk("R7 debug read refused after erase", rd_grant, 0);
      dbg = 1'b0;
      do_prog(3'd0, 16'h00FA, c);
      chk("R6 second mass-erase request", mreq_pulses, 2);
      chk("R5 R12 masks cleared and program dropped", page_wp, 0);
   endtask

   initial begin
      rst_n = 1'b0; unlock = 1'b1; erase_sel = 1'b0; start = 1'b0;
      prog_sel = 1'b0; wr_valid = 1'b0; wr_idx = '0; wr_data = '0;
      merase_done = 1'b0; dbg = 1'b0; rd_req = 1'b0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_rdp_off();
      t_masks();
      t_cfg_user();
      t_locked();
      t_busy_block();
      t_erase_wins();
      chk("R6 protection never low during request", rdp_low_in_req, 0);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      n_chk++; n_bad++;
      $display("FAIL watchdog R1..R13 run incomplete actual=hung expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule